// File: doc/BRIEF.md
# Capture/Reload Timer with External Trigger

This block is a 16-bit up/down timer-counter. It advances on a divided system-clock tick or on falling edges of an external count pin. One shared 16-bit register works either as a capture register or as a reload register. In capture mode, a falling edge on the trigger pin copies the running count into the shared register. In reload mode, the count is loaded from the shared register when it overflows, and also on a trigger edge when that edge is enabled.

Two serial-clock select bits make the timer act as a baud-rate source. While either one is set, the block always reloads on overflow and the trigger pin performs no action. Each overflow then produces a one-cycle tick on the matching serial-clock output.

Software reaches four word-wide registers through a simple synchronous write and combinational read port. The overflow flag and the trigger flag are sticky. They stay set until software writes them to zero.

Top module: `cr_timer`

## Requirements
- R1: Register map: address 0 = control, address 1 = mode, address 2 = count, address 3 = shared capture/reload register. Control bits: 0 run, 1 external count source, 2 capture mode, 3 trigger enable, 4 receive clock select, 5 transmit clock select, 6 overflow flag, 7 trigger flag. Mode bit 0 = down-count enable. After reset, every register reads 0 and both tick outputs are 0.
- R2: With run = 0, the count does not change when clock or count-pin edges occur.
- R3: With run = 1 and the internal source selected, the count increments once every PRESCALE clock cycles.
- R4: With run = 1 and the external source selected, the count increments once per falling edge of the count pin.
- R5: An up-count from all-ones sets the overflow flag. The count then becomes 0 in capture mode, or the shared register's value when reload is in effect.
- R6: With capture mode and trigger enable both set, a trigger-pin falling edge copies the count into the shared register and sets the trigger flag. The count itself is unchanged.
- R7: With capture mode clear and trigger enable set, a trigger-pin falling edge loads the count from the shared register and sets the trigger flag.
- R8: With trigger enable clear, trigger-pin edges change neither the count, the shared register nor the trigger flag.
- R9: While either serial clock select is set, the capture-mode bit is ignored. The timer reloads on overflow, and trigger edges have no effect.
- R10: Each overflow produces a single-cycle pulse on tx_tick when transmit select is set, and on rx_tick when receive select is set.
- R11: With down-count enable set, the trigger-pin level chooses the direction (1 up, 0 down) and trigger edges perform no capture or reload. A down step taken while the count equals the shared register wraps the count to all-ones and sets the overflow flag. An up overflow reloads.
- R12: Both flags stay set until software writes 0 to them through the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for reg_addr |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Trigger input, also direction in down-count mode |
| ovf_flag | output | 1 | Sticky overflow flag |
| trig_flag | output | 1 | Sticky trigger flag |
| tx_tick | output | 1 | Overflow pulse for a serial transmit clock |
| rx_tick | output | 1 | Overflow pulse for a serial receive clock |

## Verification
The bench builds the block with W = 16 and PRESCALE = 3. The short prescaler lets the exact tick cadence of the internal source be checked within a few dozen cycles, while keeping the full 16-bit wrap behaviour. Because counts can be preset near all-ones, overflow, reload and down-count wrap can each be reached with a handful of count-pin edges. Randomised runs near the top of the range mix capture and reload modes.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CAP  = 2'd3;

    // Control register; the last field is bit 0.
    typedef struct packed {
        logic trig_flag;
        logic ovf_flag;
        logic tx_sel;
        logic rx_sel;
        logic trig_en;
        logic cap_mode;
        logic ext_src;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cr_pin_sync.sv
module cr_pin_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= pin;
            s2   <= s1;
            prev <= s2;
        end
    end

    assign level = s2;
    assign fall  = prev & ~s2;
endmodule

// File: rtl/cr_prescaler.sv
module cr_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pres;

    assign tick = en && (pres == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en || tick) pres <= '0;
        else                    pres <= pres + 1'b1;
    end
endmodule

// File: rtl/cr_core.sv
module cr_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         cap_mode,
    input  logic         trig_en,
    input  logic         baud_sel,
    input  logic         down_en,
    input  logic         dir_level,
    input  logic         trig_fall,
    input  logic         cnt_wr,
    input  logic         cap_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] capreg,
    output logic         ovf_evt,
    output logic         trig_evt
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic         reload_on_ovf, go_up, wrap_up, wrap_dn, trig_act;
    logic [W-1:0] cnt_n, cap_n;

    always_comb begin
        reload_on_ovf = ~cap_mode | baud_sel | down_en;
        trig_act      = trig_fall & trig_en & ~baud_sel & ~down_en;
        go_up         = ~down_en | dir_level;
        wrap_up       = step & go_up & (count == ALL_ONES);
        wrap_dn       = step & ~go_up & (count == capreg);
        ovf_evt       = wrap_up | wrap_dn;
        trig_evt      = trig_act;

        if (cnt_wr)                    cnt_n = wdata;
        else if (trig_act & ~cap_mode) cnt_n = capreg;
        else if (wrap_up)              cnt_n = reload_on_ovf ? capreg : '0;
        else if (wrap_dn)              cnt_n = ALL_ONES;
        else if (step)                 cnt_n = go_up ? count + 1'b1 : count - 1'b1;
        else                           cnt_n = count;

        if (cap_wr)                   cap_n = wdata;
        else if (trig_act & cap_mode) cap_n = count;
        else                          cap_n = capreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            capreg <= '0;
        end else begin
            count  <= cnt_n;
            capreg <= cap_n;
        end
    end
endmodule

// File: rtl/cr_timer.sv
module cr_timer
    import cr_timer_pkg::*;
#(
    parameter int W        = 16,
    parameter int PRESCALE = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    output logic              ovf_flag,
    output logic              trig_flag,
    output logic              tx_tick,
    output logic              rx_tick
);
    ctrl_t        ctrl_q, ctrl_n;
    logic         down_en_q;
    logic         cnt_lvl, cnt_fall, trig_lvl, trig_fall;
    logic         pres_tick, step, ovf_evt, trig_evt;
    logic [W-1:0] count, capreg;

    cr_pin_sync u_cnt_sync (
        .clk(clk), .rst(rst), .pin(cnt_pin), .level(cnt_lvl), .fall(cnt_fall)
    );

    cr_pin_sync u_trig_sync (
        .clk(clk), .rst(rst), .pin(trig_pin), .level(trig_lvl), .fall(trig_fall)
    );

    cr_prescaler #(.DIV(PRESCALE)) u_pres (
        .clk(clk), .rst(rst), .en(ctrl_q.run & ~ctrl_q.ext_src), .tick(pres_tick)
    );

    assign step = ctrl_q.run & (ctrl_q.ext_src ? cnt_fall : pres_tick);

    cr_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .cap_mode  (ctrl_q.cap_mode),
        .trig_en   (ctrl_q.trig_en),
        .baud_sel  (ctrl_q.rx_sel | ctrl_q.tx_sel),
        .down_en   (down_en_q),
        .dir_level (trig_lvl),
        .trig_fall (trig_fall),
        .cnt_wr    (reg_wr && reg_addr == A_CNT),
        .cap_wr    (reg_wr && reg_addr == A_CAP),
        .wdata     (reg_wdata),
        .count     (count),
        .capreg    (capreg),
        .ovf_evt   (ovf_evt),
        .trig_evt  (trig_evt)
    );

    always_comb begin
        ctrl_n = ctrl_q;
        if (reg_wr && reg_addr == A_CTRL) ctrl_n = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        ctrl_n.ovf_flag  = ctrl_n.ovf_flag  | ovf_evt;
        ctrl_n.trig_flag = ctrl_n.trig_flag | trig_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            down_en_q <= 1'b0;
            tx_tick   <= 1'b0;
            rx_tick   <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_n;
            tx_tick <= ovf_evt & ctrl_q.tx_sel;
            rx_tick <= ovf_evt & ctrl_q.rx_sel;
            if (reg_wr && reg_addr == A_MODE) down_en_q <= reg_wdata[0];
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
            A_MODE:  reg_rdata = {{(W-1){1'b0}}, down_en_q};
            A_CNT:   reg_rdata = count;
            default: reg_rdata = capreg;
        endcase
    end

    assign ovf_flag  = ctrl_q.ovf_flag;
    assign trig_flag = ctrl_q.trig_flag;
endmodule

// File: rtl/cr_timer_chk.sv
module cr_timer_chk
    import cr_timer_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst,
    input ctrl_t             ctrl,
    input logic              down_en,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [W-1:0]      cnt,
    input logic [W-1:0]      cap,
    input logic              trig_fall,
    input logic              step,
    input logic              dir_up,
    input logic              tx_tick
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    // R2
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !reg_wr && !trig_fall) |=> cnt == $past(cnt));

    // R8
    no_trig_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.trig_en && !(reg_wr && reg_addr == A_CAP)) |=> cap == $past(cap));

    // R6
    trig_flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.trig_flag) |-> ($past(ctrl.trig_en) || $past(reg_wr)));

    // R10
    tx_tick_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tx_tick |-> (ctrl.ovf_flag && $past(ctrl.tx_sel)));

    // R11
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && down_en && !dir_up && cnt == cap && !reg_wr)
        |=> (cnt == ALL_ONES && ctrl.ovf_flag));

    // R5
    up_wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (step && (!down_en || dir_up) && cnt == ALL_ONES && !reg_wr) |=> ctrl.ovf_flag);
endmodule

bind cr_timer cr_timer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl_q),
    .down_en   (down_en_q),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .cnt       (count),
    .cap       (capreg),
    .trig_fall (trig_fall),
    .step      (step),
    .dir_up    (trig_lvl),
    .tx_tick   (tx_tick)
);

// File: tb/cr_timer_bench.sv
module cr_timer_bench;
    localparam int W  = 16;
    localparam int PS = 3;

    localparam logic [15:0] RUN = 16'h01, EXT = 16'h02, CAPM = 16'h04, TEN = 16'h08;
    localparam logic [15:0] RXS = 16'h10, TXS = 16'h20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         cnt_pin = 1'b1;
    logic         trig_pin = 1'b1;
    logic         ovf_flag, trig_flag, tx_tick, rx_tick;

    int tests = 0, fails = 0, tx_seen = 0, rx_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cr_timer #(.W(W), .PRESCALE(PS)) u_cr_timer (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .ovf_flag(ovf_flag), .trig_flag(trig_flag),
        .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    always @(negedge clk) begin
        if (tx_tick) tx_seen++;
        if (rx_tick) rx_seen++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the following rising edge
    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cnt_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_pin = 1'b0; idle(3);
            cnt_pin = 1'b1; idle(3);
        end
    endtask

    task automatic trig_fall_edge();
        trig_pin = 1'b0; idle(4);
        trig_pin = 1'b1; idle(4);
    endtask

    function automatic logic [16:0] model_up(input logic [15:0] start, input int n,
                                             input logic capm, input logic [15:0] rl);
        logic [15:0] c = start;
        logic        o = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (c == 16'hFFFF) begin o = 1'b1; c = capm ? 16'h0 : rl; end
            else c = c + 16'h1;
        end
        return {o, c};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d;
        logic [16:0]  exp;
        void'($urandom(32'd7));
        idle(3);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); check("R1 reset reg", 32'(d), 32'h0);
        end
        check("R1 ticks", {30'd0, tx_tick, rx_tick}, 32'h0);
        @(negedge clk);

        // R3 internal source, one step per PS clocks
        wr(2, 16'h0);
        wr(0, RUN);
        idle(29);
        wr(0, 16'h0);
        rd(2, d); check("R3 internal count", 32'(d), 32'd10);
        @(negedge clk);

        // R2 stopped: no change over time or count edges
        idle(20);
        wr(0, EXT);
        cnt_pulses(3);
        rd(2, d); check("R2 hold", 32'(d), 32'd10);
        @(negedge clk);

        // R4 external source
        wr(2, 16'h00F0);
        wr(0, RUN | EXT);
        cnt_pulses(5);
        rd(2, d); check("R4 external count", 32'(d), 32'h00F5);
        @(negedge clk);

        // R5 capture-mode wrap to zero
        wr(3, 16'h1234);
        wr(2, 16'hFFFE);
        wr(0, RUN | EXT | CAPM);
        cnt_pulses(3);
        rd(2, d); check("R5 capture wrap", 32'(d), 32'h0001);
        check("R5 ovf flag", 32'(ovf_flag), 32'd1);
        @(negedge clk);
        // R12 sticky flag cleared by software only
        idle(10);
        check("R12 flag sticky", 32'(ovf_flag), 32'd1);
        wr(0, RUN | EXT | CAPM);
        check("R12 flag cleared", 32'(ovf_flag), 32'd0);

        // R5 reload-mode wrap
        wr(2, 16'hFFFF);
        wr(0, RUN | EXT);
        cnt_pulses(2);
        rd(2, d); check("R5 reload wrap", 32'(d), 32'h1235);
        check("R5 ovf flag reload", 32'(ovf_flag), 32'd1);
        @(negedge clk);

        // R6 capture on trigger
        wr(0, CAPM | TEN);
        wr(2, 16'hBEEF);
        trig_fall_edge();
        rd(3, d); check("R6 captured", 32'(d), 32'hBEEF);
        rd(2, d); check("R6 count kept", 32'(d), 32'hBEEF);
        check("R6 trig flag", 32'(trig_flag), 32'd1);
        @(negedge clk);

        // R8 trigger disabled
        wr(0, CAPM);
        wr(2, 16'h0042);
        trig_fall_edge();
        rd(3, d); check("R8 no capture", 32'(d), 32'hBEEF);
        check("R8 no flag", 32'(trig_flag), 32'd0);
        @(negedge clk);
        wr(0, 16'h0);
        trig_fall_edge();
        rd(2, d); check("R8 no reload", 32'(d), 32'h0042);
        @(negedge clk);

        // R7 reload on trigger
        wr(0, TEN);
        wr(3, 16'h4321);
        wr(2, 16'h0005);
        trig_fall_edge();
        rd(2, d); check("R7 trig reload", 32'(d), 32'h4321);
        check("R7 trig flag", 32'(trig_flag), 32'd1);
        @(negedge clk);

        // R9 receive select: trigger ignored, reload forced
        tx_seen = 0; rx_seen = 0;
        wr(0, RXS | CAPM | TEN | RUN | EXT);
        wr(3, 16'h0777);
        wr(2, 16'hFFFF);
        trig_fall_edge();
        rd(3, d); check("R9 no capture", 32'(d), 32'h0777);
        check("R9 no trig flag", 32'(trig_flag), 32'd0);
        @(negedge clk);
        cnt_pulses(1);
        rd(2, d); check("R9 forced reload", 32'(d), 32'h0777);
        check("R10 rx pulses", 32'(rx_seen), 32'd1);
        check("R10 tx none", 32'(tx_seen), 32'd0);
        @(negedge clk);

        // R10 transmit tick
        tx_seen = 0; rx_seen = 0;
        wr(0, TXS | RUN | EXT);
        wr(2, 16'hFFFE);
        cnt_pulses(3);
        check("R10 tx pulses", 32'(tx_seen), 32'd1);
        check("R10 rx none", 32'(rx_seen), 32'd0);

        // R11 down count
        wr(1, 16'h1);
        wr(0, RUN | EXT | CAPM | TEN);
        wr(3, 16'h0001);
        wr(2, 16'h0003);
        trig_pin = 1'b0; idle(5);
        rd(3, d); check("R11 no capture", 32'(d), 32'h0001);
        check("R11 no trig flag", 32'(trig_flag), 32'd0);
        @(negedge clk);
        cnt_pulses(2);
        rd(2, d); check("R11 down steps", 32'(d), 32'h0001);
        check("R11 no ovf yet", 32'(ovf_flag), 32'd0);
        @(negedge clk);
        cnt_pulses(1);
        rd(2, d); check("R11 down wrap", 32'(d), 32'hFFFF);
        check("R11 ovf flag", 32'(ovf_flag), 32'd1);
        @(negedge clk);
        trig_pin = 1'b1; idle(5);
        cnt_pulses(1);
        rd(2, d); check("R11 up reload", 32'(d), 32'h0001);
        @(negedge clk);
        wr(1, 16'h0);

        // R5 randomised near the top of the range
        for (int t = 0; t < 16; t++) begin
            logic [15:0] st, rl;
            logic        cm;
            int          n;
            st = 16'hFFFF - 16'($urandom % 6);
            rl = 16'($urandom);
            cm = 1'($urandom % 2);
            n  = 1 + int'($urandom % 8);
            wr(0, 16'h0);
            wr(3, rl);
            wr(2, st);
            wr(0, RUN | EXT | (cm ? CAPM : 16'h0));
            cnt_pulses(n);
            exp = model_up(st, n, cm, rl);
            rd(2, d); check("R5 random count", 32'(d), 32'(exp[15:0]));
            check("R5 random ovf", 32'(ovf_flag), 32'(exp[16]));
            @(negedge clk);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule